// File: doc/BRIEF.md
# Bus-Strobed Serial Configuration Loader

This block sits on a host bus as a slave and takes in a serial configuration image one bit per bus cycle. It watches the 24-bit address, the active-low address strobe and an active-high presence-sense input. When all three qualify, it drives an active-low write strobe to the device being configured. When that strobe is released, the block takes data line 0 into a shift register and advances a bit counter.

Once the counter reaches the image length, the block raises a done flag and ignores any further loader cycles. Two things clear the counter, the shift register and the done flag: an asynchronous active-low reset, and a synchronous power-down input. After either, the image has to be sent again. Each captured bit gives a one-cycle acknowledge pulse.

Top module: `cfg_bit_loader`

## Requirements
- R1: `wr_n` is low, combinationally, exactly when `as_n` is low, `sense` is high, and `bus_addr & 24'hFE0200 == 24'h740200`. All address bits outside that mask are don't-care, so the nominal address is 24'h740200.
- R2: While `sense` is low, `wr_n` stays high, and `bit_count`, `shift_data` and `done` do not change.
- R3: Each low pulse of `wr_n` captures exactly one bit. On the first clock edge at which the qualification has dropped after being seen, `bit_count` rises by one and `ack` is high for exactly one cycle.
- R4: The captured bit is the value `bus_d0` had at the last clock edge while `wr_n` was low. It enters `shift_data[0]`, and the older bits move up one position.
- R5: `done` rises on the same edge as the capture that brings `bit_count` to IMAGE_BITS (default 17878), and `bit_count` equals IMAGE_BITS whenever `done` is high.
- R6: While `done` is high, a loader cycle produces no `ack` and leaves `bit_count` and `shift_data` unchanged, although `wr_n` still follows R1.
- R7: Taking `rst_n` low clears `bit_count`, `shift_data`, `done` and `ack` at once.
- R8: `pwr_down` high at a clock edge clears the same state as R7, and no capture takes place while it stays high.
- R9: Holding `wr_n` low for several clock cycles still counts as a single bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| pwr_down | input | 1 | Synchronous power-down; loses the loaded state |
| bus_addr | input | 24 | Host bus address |
| as_n | input | 1 | Address strobe, active low |
| bus_d0 | input | 1 | Data line 0, carries the configuration bit |
| sense | input | 1 | Presence sense, active high |
| wr_n | output | 1 | Write strobe to the configured device, active low |
| ack | output | 1 | One-cycle pulse per captured bit |
| bit_count | output | $clog2(IMAGE_BITS+1) | Bits captured so far |
| shift_data | output | SHIFT_W | Most recent captured bits, newest in bit 0 |
| done | output | 1 | Full image received |

## Verification
`wr_n` is pure combinational logic. The bench therefore checks it one time unit after the inputs change in the falling half of the clock. The capture is due on the first rising edge after the strobe is released. The bench checks `bit_count`, `shift_data`, `done` and `ack` at the falling edge that follows that rising edge, and checks again one cycle later to confirm that `ack` has dropped. A power-down is checked at the falling edge after the rising edge that sampled it. A reset is checked immediately, because it acts asynchronously.

// File: rtl/cfg_bit_loader.sv
module cfg_bit_loader #(
  parameter int          ADDR_W     = 24,
  parameter logic [23:0] MATCH_VAL  = 24'h740200,
  parameter logic [23:0] MATCH_MASK = 24'hFE0200,
  parameter int          IMAGE_BITS = 17878,
  parameter int          SHIFT_W    = 32,
  localparam int         CW         = $clog2(IMAGE_BITS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_down,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              as_n,
  input  logic              bus_d0,
  input  logic              sense,
  output logic              wr_n,
  output logic              ack,
  output logic [CW-1:0]     bit_count,
  output logic [SHIFT_W-1:0] shift_data,
  output logic              done
);

  localparam logic [CW-1:0] LAST = CW'(IMAGE_BITS - 1);

  logic hit;
  logic strobe_q;
  logic d0_hold;
  logic release_edge;

  assign hit = ((bus_addr & MATCH_MASK) == (MATCH_VAL & MATCH_MASK)) && !as_n && sense;
  assign wr_n = ~hit;
  assign release_edge = strobe_q && !hit && !done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q   <= 1'b0;
      d0_hold    <= 1'b0;
      ack        <= 1'b0;
      bit_count  <= '0;
      shift_data <= '0;
      done       <= 1'b0;
    end else if (pwr_down) begin
      strobe_q   <= 1'b0;
      d0_hold    <= 1'b0;
      ack        <= 1'b0;
      bit_count  <= '0;
      shift_data <= '0;
      done       <= 1'b0;
    end else begin
      strobe_q <= hit;
      ack      <= release_edge;
      if (hit) d0_hold <= bus_d0;
      if (release_edge) begin
        bit_count  <= bit_count + 1'b1;
        shift_data <= {shift_data[SHIFT_W-2:0], d0_hold};
        if (bit_count == LAST) done <= 1'b1;
      end
    end
  end

endmodule

module cfg_bit_loader_chk #(
  parameter int IMAGE_BITS = 17878,
  parameter int CW         = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pwr_down,
  input logic          as_n,
  input logic          sense,
  input logic          wr_n,
  input logic          ack,
  input logic [CW-1:0] bit_count,
  input logic          done
);

  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n) as_n |-> wr_n);

  p_sense_gate_r2: assert property (@(posedge clk) disable iff (!rst_n) !sense |-> wr_n);

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_down |=> (ack ? (bit_count == CW'($past(bit_count) + 1'b1)) : (bit_count == $past(bit_count))));

  p_done_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (bit_count == CW'(IMAGE_BITS)));

  p_done_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !pwr_down) |=> (done && !ack));

  p_pwr_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> (bit_count == '0 && !done && !ack));

endmodule

bind cfg_bit_loader cfg_bit_loader_chk #(.IMAGE_BITS(IMAGE_BITS), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .as_n(as_n), .sense(sense),
  .wr_n(wr_n), .ack(ack), .bit_count(bit_count), .done(done)
);

// File: tb/cfg_bit_loader_test.sv
module cfg_bit_loader_test;
  localparam int CLK_PERIOD = 10;
  localparam int NBITS = 40;
  localparam int SW = 16;
  localparam int CW = $clog2(NBITS + 1);
  localparam logic [23:0] NOM = 24'h740200;
  localparam logic [23:0] MASK = 24'hFE0200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_down = 1'b0;
  logic [23:0] bus_addr = '0;
  logic as_n = 1'b1;
  logic bus_d0 = 1'b0;
  logic sense = 1'b0;
  logic wr_n, ack, done;
  logic [CW-1:0] bit_count;
  logic [SW-1:0] shift_data;

  int errors = 0;
  int checks = 0;
  int exp_count = 0;
  logic [SW-1:0] exp_shift = '0;
  bit finished = 1'b0;

  cfg_bit_loader #(.IMAGE_BITS(NBITS), .SHIFT_W(SW)) uut (
    .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .bus_addr(bus_addr), .as_n(as_n),
    .bus_d0(bus_d0), .sense(sense), .wr_n(wr_n), .ack(ack), .bit_count(bit_count),
    .shift_data(shift_data), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_state(input string req, input logic exp_ack);
    chk({req, " count"}, 32'(bit_count), 32'(exp_count));
    chk({req, " shift"}, 32'(shift_data), 32'(exp_shift));
    chk({req, " done"}, 32'(done), 32'(exp_count == NBITS));
    chk({req, " ack"}, 32'(ack), 32'(exp_ack));
  endtask

  // one loader cycle; captures if enabled and not done
  task automatic write_bit(input logic b, input int hold, input bit captures, input string req);
    @(negedge clk);
    bus_addr = NOM; as_n = 1'b0; bus_d0 = b;
    repeat (hold) @(negedge clk);
    as_n = 1'b1; bus_d0 = ~b;
    @(negedge clk);
    if (captures) begin
      exp_count++;
      exp_shift = {exp_shift[SW-2:0], b};
    end
    check_state(req, captures);
    @(negedge clk);
    chk({req, " ack drop"}, 32'(ack), 32'd0);
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 200000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected<=200000", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    #1;
    check_state("R7 reset", 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    sense = 1'b1;

    // R1: flip each address bit; match iff bit outside mask
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      bus_addr = NOM ^ (24'd1 << i); as_n = 1'b0;
      #1 chk($sformatf("R1 flip bit %0d", i), 32'(wr_n), 32'(MASK[i]));
      @(negedge clk);
      as_n = 1'b1;
    end
    @(negedge clk);
    bus_addr = NOM | ~MASK; as_n = 1'b0;
    #1 chk("R1 all dont-care set", 32'(wr_n), 32'd0);
    @(negedge clk);
    as_n = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      bus_addr = NOM; as_n = k[0]; sense = k[1];
      #1 chk($sformatf("R1 as_n=%0d sense=%0d", k[0], k[1]), 32'(wr_n), 32'(!(!k[0] && k[1])));
    end
    @(negedge clk);
    as_n = 1'b1; sense = 1'b1;

    // R7: async reset mid-cycle
    @(negedge clk);
    #2 rst_n = 1'b0;
    #1;
    exp_count = 0; exp_shift = '0;
    check_state("R7 async clear", 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2: sense low blocks loading
    sense = 1'b0;
    write_bit(1'b1, 2, 1'b0, "R2 sense low");
    sense = 1'b1;

    // R3 R4 R9: load full image, holds 1..3
    for (int i = 0; i < NBITS; i++) begin
      logic b;
      b = ((i * 7 + 3) % 5) < 2;
      write_bit(b, 1 + (i % 3), 1'b1, (i % 3 == 0) ? "R3 R4 capture" : "R9 R4 long hold");
    end
    chk("R5 done", 32'(done), 32'd1);

    // R6: ignored after done, but strobe still driven
    @(negedge clk);
    bus_addr = NOM; as_n = 1'b0; bus_d0 = 1'b1;
    #1 chk("R6 wr_n still decodes", 32'(wr_n), 32'd0);
    @(negedge clk);
    as_n = 1'b1;
    @(negedge clk);
    check_state("R6 after done", 1'b0);

    // R8: power-down clears, and blocks while held
    @(negedge clk);
    pwr_down = 1'b1;
    @(negedge clk);
    exp_count = 0; exp_shift = '0;
    check_state("R8 pwr_down clear", 1'b0);
    write_bit(1'b1, 1, 1'b0, "R8 held pwr_down");
    pwr_down = 1'b0;
    write_bit(1'b1, 1, 1'b1, "R8 reload after pwr_down");
    write_bit(1'b0, 2, 1'b1, "R4 reload second bit");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule